// File: doc/BRIEF.md
# External Interrupt Sense Conditioner

This block sits between two asynchronous external interrupt pins and a downstream interrupt controller. That controller only accepts active-high level requests or rising-edge requests. Each pin passes through a two-stage synchronizer. Its sense is then corrected according to a per-line configuration word, so that the line drives its own request output in the form the controller expects.

An active-low level source appears downstream as an active-high level. A falling-edge source appears downstream as a single-cycle rising pulse.

Software programs each line through a small register bus with combinational reads. Each line's word holds an enable, a level/edge select and a polarity bit. Software can read the word back, which lets it save and restore the configuration. A read-only status word always reports that filter configuration is ready. Rewriting a line's configuration re-seeds its edge history, so a polarity change never produces a false pulse.

Top module: `xint_sense`

## Requirements
- R1: After reset both configuration words read zero and both request outputs are low.
- R2: Offset 0x0 is a read-only status word that reads 0x0000_0001, and writes to it have no effect.
- R3: Line n's configuration word sits at offset 0x4 + 4n. Only bit 16 (enable), bit 9 (level select) and bit 8 (polarity) are stored, all other bits read as zero, and a write replaces all three bits.
- R4: With bit 9 set, the request follows the pin two clock edges after the pin changes. It is active-high when bit 8 is 1 and inverted when bit 8 is 0.
- R5: With bit 9 clear, the request is a single-cycle pulse two clock edges after the selected transition of the pin. The transition is rising when bit 8 is 0 and falling when bit 8 is 1.
- R6: While bit 16 of a line is clear, that line's request stays low whatever the pin does.
- R7: Reads from any offset other than 0x0, 0x4 and 0x8 return zero, and writes to those offsets change no configuration word.
- R8: Writing a line's configuration word never produces a request pulse by itself. Only a transition of the pin after the write can produce one.
- R9: The two lines are independent: the pin and configuration of one line never affect the other line's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, taken at the clock edge when bus_sel is high |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_sel is high |
| pin_in | input | 2 | Asynchronous external interrupt pins |
| req_out | output | 2 | Normalized requests to the interrupt controller |

## Verification
A pin change is due at req_out after the second rising clock edge that samples it. In edge mode the pulse then lasts exactly one cycle. A configuration write takes effect at the edge that accepts it, and read data is due in the same cycle as the address.

The bench drives all inputs on the falling edge. Its reference model advances on the rising edge by the same rules. Every falling edge compares both requests against the model, so every latency is checked at exactly its due cycle. Register reads are sampled a short delay after the address is applied. Pulse counts over windows confirm the single-pulse and no-spurious-pulse cases.

// File: rtl/xint_sense.sv
module xint_sense #(
  parameter int NLINES   = 2,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int CFG_BASE = 4,
  parameter int EN_BIT   = 16,
  parameter int LVL_BIT  = 9,
  parameter int POL_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] req_out
);
  localparam int STEP = 4;
  localparam logic [AW-1:0] STAT_OFS = '0;

  logic [NLINES-1:0] en_q, lvl_q, pol_q;
  logic [NLINES-1:0] sy1_q, sy2_q, hist_q;
  logic [NLINES-1:0] wr_hit, corr;
  logic              new_inv;

  assign new_inv = bus_wdata[LVL_BIT] ^ bus_wdata[POL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign wr_hit[i]  = bus_sel && bus_we && (bus_addr == AW'(CFG_BASE + STEP * i));
    assign corr[i]    = sy2_q[i] ^ (lvl_q[i] ^ pol_q[i]);
    assign req_out[i] = en_q[i] && corr[i] && (lvl_q[i] || !hist_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        lvl_q[i]  <= 1'b0;
        pol_q[i]  <= 1'b0;
        hist_q[i] <= 1'b0;
      end else if (wr_hit[i]) begin
        en_q[i]   <= bus_wdata[EN_BIT];
        lvl_q[i]  <= bus_wdata[LVL_BIT];
        pol_q[i]  <= bus_wdata[POL_BIT];
        hist_q[i] <= sy2_q[i] ^ new_inv;
      end else begin
        hist_q[i] <= corr[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == STAT_OFS) bus_rdata[0] = 1'b1;
      for (int i = 0; i < NLINES; i++) begin
        if (bus_addr == AW'(CFG_BASE + STEP * i)) begin
          bus_rdata[EN_BIT]  = en_q[i];
          bus_rdata[LVL_BIT] = lvl_q[i];
          bus_rdata[POL_BIT] = pol_q[i];
        end
      end
    end
  end
endmodule

module xint_sense_chk #(
  parameter int NLINES = 2,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic [NLINES-1:0] pin_in,
  input logic [NLINES-1:0] req_out,
  input logic [NLINES-1:0] en_q,
  input logic [NLINES-1:0] lvl_q,
  input logic [NLINES-1:0] pol_q
);
  a_r2_status_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == '0) |-> bus_rdata == DW'(1));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != AW'(0) && bus_addr != AW'(4) && bus_addr != AW'(8))
      |-> bus_rdata == '0);

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> !req_out[i]);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (req_out[i] && !lvl_q[i] && !(bus_sel && bus_we)) |=> !req_out[i]);

    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && lvl_q[i] && pol_q[i] && $stable(lvl_q[i]) && $stable(pol_q[i])
        && $past(en_q[i]) && $past(en_q[i], 2) && $past(lvl_q[i], 2) && $past(pol_q[i], 2))
        |-> req_out[i] == $past(pin_in[i], 2));
  end
endmodule

bind xint_sense xint_sense_chk #(.NLINES(NLINES), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .req_out(req_out), .en_q(en_q), .lvl_q(lvl_q), .pol_q(pol_q)
);

// File: tb/xint_sense_tb.sv
`timescale 1ns/1ps
module xint_sense_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pin_in = '0;
  logic [1:0]  req_out;

  int checks = 0, errors = 0;
  bit done = 0;
  int pulses [2];
  bit m_en [2], m_lvl [2], m_pol [2], m_hist [2], m_s1 [2], m_s2 [2], m_exp [2];

  always #4 clk = ~clk;

  xint_sense dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .req_out(req_out));

  // reference model: advances on the rising edge
  always @(posedge clk) begin
    for (int n = 0; n < 2; n++) begin
      bit w, oldc, c;
      if (!rst_n) begin
        m_en[n] = 0; m_lvl[n] = 0; m_pol[n] = 0; m_hist[n] = 0; m_s1[n] = 0; m_s2[n] = 0;
      end else begin
        w = bus_sel && bus_we && (bus_addr == 8'(4 + 4 * n));
        oldc = m_s2[n] ^ (m_lvl[n] ^ m_pol[n]);
        if (w) begin
          m_hist[n] = m_s2[n] ^ (bus_wdata[9] ^ bus_wdata[8]);
          m_en[n] = bus_wdata[16]; m_lvl[n] = bus_wdata[9]; m_pol[n] = bus_wdata[8];
        end else m_hist[n] = oldc;
        m_s2[n] = m_s1[n];
        m_s1[n] = pin_in[n];
      end
      c = m_s2[n] ^ (m_lvl[n] ^ m_pol[n]);
      m_exp[n] = m_en[n] && c && (m_lvl[n] || !m_hist[n]);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < 2; n++) begin
        checks++;
        if (req_out[n] !== m_exp[n]) begin
          errors++;
          $display("FAIL %s line%0d req actual=%b expected=%b t=%0t",
                   m_lvl[n] ? "R4/R9" : "R5/R8/R9", n, req_out[n], m_exp[n], $time);
        end
        if (req_out[n]) pulses[n]++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p0;
    pulses[0] = 0; pulses[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    chk("R1 req after reset", {30'd0, req_out}, 32'd0);
    rd(8'h04, d); chk("R1 cfg0 reset", d, 32'd0);
    rd(8'h08, d); chk("R1 cfg1 reset", d, 32'd0);
    rd(8'h00, d); chk("R2 status", d, 32'd1);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 status after write", d, 32'd1);
    rd(8'h04, d); chk("R2 write to status left cfg0", d, 32'd0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R3 cfg1 stored bits", d, 32'h0001_0300);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R3 cfg1 cleared", d, 32'd0);
    rd(8'h0C, d); chk("R7 unmapped read", d, 32'd0);
    rd(8'h05, d); chk("R7 misaligned read", d, 32'd0);
    wr(8'h0C, 32'h0001_0300);
    wr(8'h10, 32'h0001_0300);
    rd(8'h04, d); chk("R7 cfg0 untouched", d, 32'd0);
    rd(8'h08, d); chk("R7 cfg1 untouched", d, 32'd0);

    // R6: masked line with pin activity
    p0 = pulses[0];
    wr(8'h04, 32'h0000_0300);
    for (int k = 0; k < 6; k++) begin pin_in[0] = ~pin_in[0]; idle(2); end
    chk("R6 masked line pulses", pulses[0] - p0, 0);

    // R4 level high then low on line 0; line 1 rising edge
    pin_in = 2'b00;
    wr(8'h04, 32'h0001_0300);
    wr(8'h08, 32'h0001_0000);
    for (int k = 0; k < 20; k++) begin pin_in = 2'(k * 7 + k / 3); idle(1 + k % 3); end
    wr(8'h04, 32'h0001_0200);
    for (int k = 0; k < 20; k++) begin pin_in = 2'(k * 5 + 1); idle(1 + k % 4); end

    // R5 falling edge: exactly one pulse
    pin_in = 2'b01;
    wr(8'h04, 32'h0001_0100);
    idle(4);
    p0 = pulses[0];
    pin_in[0] = 0; idle(6);
    chk("R5 one pulse on fall", pulses[0] - p0, 1);
    p0 = pulses[0];
    pin_in[0] = 1; idle(6);
    chk("R5 no pulse on rise in fall mode", pulses[0] - p0, 0);

    // R8: polarity flips while pin held produce no pulse
    wr(8'h04, 32'h0001_0000);
    idle(4);
    p0 = pulses[0];
    wr(8'h04, 32'h0001_0100);
    wr(8'h04, 32'h0001_0000);
    wr(8'h04, 32'h0001_0100);
    pin_in[0] = 1; idle(4);
    wr(8'h04, 32'h0001_0000);
    idle(4);
    chk("R8 no pulse from config writes", pulses[0] - p0, 0);

    // R9: line 1 untouched by line 0 activity
    wr(8'h08, 32'h0001_0300);
    pin_in[1] = 1;
    idle(3);
    for (int k = 0; k < 8; k++) begin pin_in[0] = ~pin_in[0]; idle(1); end
    chk("R9 line1 level held", {31'd0, req_out[1]}, 32'd1);
    wr(8'h04, 32'h0);
    idle(3);
    chk("R1 line0 zero write disables", {31'd0, req_out[0]}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule